// File: doc/BRIEF.md
# BCD Calendar Nibble Registers

This block is the register side of a real-time clock and calendar. Software reaches it over a small bus with a 4-bit address, a 4-bit data path and select, read and write strobes. Each time digit is a separate 4-bit BCD register: tenths of seconds, seconds, minutes, hours, day of week, day of month and month. The digits are chained, so a carry out of one digit advances the next. Each rising edge of a slow 10 Hz tick input advances the chain by one tenth of a second. Hours count in 24-hour form. The day of month wraps at the length of the current month. February's length comes from a two-bit leap-year position register that can only be written.

Software can see that the time changed in the middle of a multi-digit read. A flag is set on every advance and cleared by every read. While the flag is set, a read returns the illegal BCD code 1111 in place of the register. A stop latch holds the sub-minute digits at zero, which lets software start the seconds at a known instant.

Top module: `rtc_nibble_regs`

## Requirements
- R1: A read cycle (select and read high at a rising clock edge) presents the addressed nibble on the read data port from the next cycle, for that one cycle. In every other cycle the read data is 0000. Addresses: 1 tenths, 2 seconds units, 3 seconds tens, 4 minutes units, 5 minutes tens, 6 hours units, 7 hours tens, 8 day of week, 9 day units, 10 day tens, 11 month units, 12 month tens. Addresses 0, 13, 14 and 15 read as 0000.
- R2: The narrower registers store only their low bits on write and read back 0 in the unused upper bits. Field widths: seconds tens 3, minutes tens 3, hours tens 2, day of week 3, day tens 2, month tens 1, leap position 2.
- R3: Each rising edge of the tick input, seen as a low-to-high change between two clock samples, advances tenths by one. Tenths wraps 9 to 0 and carries into seconds, which wrap at 59 and carry into minutes. Minutes wrap at 59 and carry into hours. A tick held high for several cycles advances the count once.
- R4: Hours count 00 to 23. A carry out of minutes at 23 gives 00 and advances the day.
- R5: The day of month wraps to 01 after day 30 in months 4, 6, 9 and 11, after day 31 in the other months, and after day 28 or 29 in month 2. Months wrap 12 to 01. Day of week runs 1 to 7 and advances with each day.
- R6: The data-changed flag is 0 after reset. It is set in each cycle that holds a tick rising edge. Otherwise any read cycle clears it.
- R7: A read cycle returns 1111 if the flag is set, or if a tick rising edge falls in the same cycle.
- R8: Writing 1 to bit 0 of address 14 sets the stop latch. From the next cycle, and for as long as the latch is set, tenths and both seconds digits read 0, no carry reaches the minutes, and ticks have no effect on them. Writing 0 releases the latch.
- R9: A write cycle loads the minute, hour, day of week, day and month registers from the data bus. A write to the same digit in a cycle with a tick edge takes priority over that digit's advance. Writes to addresses 0, 1, 2, 3 and 15 change nothing.
- R10: Address 13 holds the leap position in its low two bits. Position 0 gives February 29 days, any other value 28 days. The position advances by one, modulo 4, when the month wraps from 12 to 01.
- R11: After reset the time reads 00:00:00.0, day 01, month 01, day of week 1. The leap position is 0 and the stop latch is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_10hz | input | 1 | Slow time base; each rising edge advances one tenth |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high, qualified by select |
| bus_wr | input | 1 | Write strobe, active high, qualified by select |
| bus_addr | input | 4 | Nibble address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Registered read data, 0000 outside read results |

## Verification
A counter advance and a bus read can land in the same clock cycle. The bench provokes this by raising the tick input in the same cycle as a read strobe. It expects 1111 from that read, expects the next read to return 1111 again because the flag stays set, and expects the read after that to return the updated digit. A write and an advance can also coincide. The bench loads a minute digit in the cycle of a tick edge and checks that the written value survives. The reference model updates on every clock and is compared with the read data port each cycle. Digit rollovers are reached through the stop latch and long runs of ticks.

// File: rtl/rtc_pkg.sv
// Shared constants and types for the BCD calendar nibble registers.
// Assumes a 4-bit address and 4-bit data bus, one BCD digit per address.
package rtc_pkg;
    localparam int DATA_W      = 4;
    localparam int ADDR_W      = 4;
    localparam int TIME_DIGITS = 5;   // tenths, sec units, sec tens, min units, min tens
    localparam int HELD_DIGITS = 3;   // digits zeroed by the stop latch
    localparam int DIGIT_LAST [TIME_DIGITS] = '{9, 9, 5, 9, 5};
    localparam int DIGIT_W    [TIME_DIGITS] = '{4, 4, 3, 4, 3};

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] nib_t;

    localparam addr_t A_CTRL   = 4'd0;
    localparam addr_t A_TENTHS = 4'd1;
    localparam addr_t A_MINU   = 4'd4;
    localparam addr_t A_MINT   = 4'd5;
    localparam addr_t A_HRU    = 4'd6;
    localparam addr_t A_HRT    = 4'd7;
    localparam addr_t A_DOW    = 4'd8;
    localparam addr_t A_DAYU   = 4'd9;
    localparam addr_t A_DAYT   = 4'd10;
    localparam addr_t A_MONU   = 4'd11;
    localparam addr_t A_MONT   = 4'd12;
    localparam addr_t A_LEAP   = 4'd13;
    localparam addr_t A_HOLD   = 4'd14;
    localparam addr_t A_IRQ    = 4'd15;

    typedef struct packed {
        logic [3:0] hr_u;
        logic [1:0] hr_t;
        logic [2:0] dow;
        logic [3:0] day_u;
        logic [1:0] day_t;
        logic [3:0] mon_u;
        logic       mon_t;
    } cal_t;
endpackage

// File: rtl/rtc_digit.sv
// One modulo-(LAST+1) BCD digit with clear, parallel load and increment.
// Priority: clear, then load, then increment. Carry is combinational and
// suppressed while cleared. Assumes LAST fits in W bits.
module rtc_digit #(
    parameter int W    = 4,
    parameter int LAST = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     inc,
    input  logic                     ld,
    input  logic [W-1:0]             ld_val,
    output logic [rtc_pkg::DATA_W-1:0] val,
    output logic                     carry
);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    logic [W-1:0] q;

    // Digit state: clear, load or count.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (clr)    q <= '0;
        else if (ld)     q <= ld_val;
        else if (inc)    q <= (q == LAST_V) ? '0 : q + 1'b1;
    end

    assign carry = inc && !clr && (q == LAST_V);
    assign val   = rtc_pkg::DATA_W'(q);
endmodule

// File: rtl/rtc_calendar.sv
// Hours, day of week, day of month, month and leap position.
// Advanced by the carry out of the minutes; each field can be loaded from the
// bus, and a load wins over the advance for that field. Assumes legal BCD.
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  min_carry,
    input  logic  wr_en,
    input  addr_t addr,
    input  nib_t  wdata,
    output cal_t  cal,
    output logic [1:0] leap
);
    logic [7:0] dim_bcd;
    logic       hour_wrap, day_end, year_wrap;
    logic       day_carry, mon_carry, year_carry;

    // Last day of the current month in BCD.
    always_comb begin
        case ({3'b000, cal.mon_t, cal.mon_u})
            8'h02:                      dim_bcd = (leap == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: dim_bcd = 8'h30;
            default:                    dim_bcd = 8'h31;
        endcase
    end

    assign hour_wrap  = ({cal.hr_t, cal.hr_u} == 6'h23);
    assign day_end    = ({2'b00, cal.day_t, cal.day_u} == dim_bcd);
    assign year_wrap  = ({cal.mon_t, cal.mon_u} == 5'h12);
    assign day_carry  = min_carry && hour_wrap;
    assign mon_carry  = day_carry && day_end;
    assign year_carry = mon_carry && year_wrap;

    // Hour digits, 24-hour count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal.hr_u <= '0;
            cal.hr_t <= '0;
        end else begin
            if (wr_en && addr == A_HRU)  cal.hr_u <= wdata;
            else if (min_carry)          cal.hr_u <= (hour_wrap || cal.hr_u == 4'd9) ? 4'd0 : cal.hr_u + 4'd1;
            if (wr_en && addr == A_HRT)  cal.hr_t <= wdata[1:0];
            else if (min_carry)          cal.hr_t <= hour_wrap ? 2'd0 :
                                                     (cal.hr_u == 4'd9) ? cal.hr_t + 2'd1 : cal.hr_t;
        end
    end

    // Day-of-month digits and day of week.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal.day_u <= 4'd1;
            cal.day_t <= '0;
            cal.dow   <= 3'd1;
        end else begin
            if (wr_en && addr == A_DAYU) cal.day_u <= wdata;
            else if (day_carry)          cal.day_u <= day_end ? 4'd1 :
                                                      (cal.day_u == 4'd9) ? 4'd0 : cal.day_u + 4'd1;
            if (wr_en && addr == A_DAYT) cal.day_t <= wdata[1:0];
            else if (day_carry)          cal.day_t <= day_end ? 2'd0 :
                                                      (cal.day_u == 4'd9) ? cal.day_t + 2'd1 : cal.day_t;
            if (wr_en && addr == A_DOW)  cal.dow <= wdata[2:0];
            else if (day_carry)          cal.dow <= (cal.dow == 3'd7) ? 3'd1 : cal.dow + 3'd1;
        end
    end

    // Month digits and leap position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal.mon_u <= 4'd1;
            cal.mon_t <= 1'b0;
            leap      <= '0;
        end else begin
            if (wr_en && addr == A_MONU) cal.mon_u <= wdata;
            else if (mon_carry)          cal.mon_u <= year_wrap ? 4'd1 :
                                                      (cal.mon_u == 4'd9) ? 4'd0 : cal.mon_u + 4'd1;
            if (wr_en && addr == A_MONT) cal.mon_t <= wdata[0];
            else if (mon_carry)          cal.mon_t <= year_wrap ? 1'b0 :
                                                      (cal.mon_u == 4'd9) ? 1'b1 : cal.mon_t;
            if (wr_en && addr == A_LEAP) leap <= wdata[1:0];
            else if (year_carry)         leap <= leap + 2'd1;
        end
    end
endmodule

// File: rtl/rtc_nibble_regs.sv
// Top of the BCD calendar registers: tick edge detect, sub-minute digit chain,
// calendar, stop latch, data-changed flag and registered read port.
// Assumes tick_10hz is synchronous to clk and slower than two clock cycles.
module rtc_nibble_regs
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_10hz,
    input  logic       bus_sel,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [3:0] bus_addr,
    input  logic [3:0] bus_wdata,
    output logic [3:0] bus_rdata
);
    logic tick_q, step, changed_q, hold_q;
    logic rd_en, wr_en;
    nib_t rd_mux, rdata_q;
    logic [TIME_DIGITS-1:0] carry;
    nib_t dig_val [TIME_DIGITS];
    cal_t cal;
    logic [1:0] leap;

    assign rd_en = bus_sel && bus_rd;
    assign wr_en = bus_sel && bus_wr;
    assign step  = tick_10hz && !tick_q;

    // Sub-minute and minute digits, chained by carry.
    for (genvar i = 0; i < TIME_DIGITS; i++) begin : g_dig
        localparam int W = DIGIT_W[i];
        logic inc_i, clr_i, ld_i;
        if (i == 0) begin : g_first
            assign inc_i = step;
        end else begin : g_next
            assign inc_i = carry[i-1];
        end
        if (i < HELD_DIGITS) begin : g_held
            assign clr_i = hold_q;
            assign ld_i  = 1'b0;
        end else begin : g_load
            assign clr_i = 1'b0;
            assign ld_i  = wr_en && (bus_addr == addr_t'(int'(A_TENTHS) + i));
        end
        rtc_digit #(.W(W), .LAST(DIGIT_LAST[i])) u_dig (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_i),
            .inc    (inc_i),
            .ld     (ld_i),
            .ld_val (bus_wdata[W-1:0]),
            .val    (dig_val[i]),
            .carry  (carry[i])
        );
    end

    rtc_calendar u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .min_carry (carry[TIME_DIGITS-1]),
        .wr_en     (wr_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .cal       (cal),
        .leap      (leap)
    );

    // Read multiplexer over the addressable digits.
    always_comb begin
        case (bus_addr)
            A_MINU:  rd_mux = dig_val[3];
            A_MINT:  rd_mux = dig_val[4];
            A_HRU:   rd_mux = cal.hr_u;
            A_HRT:   rd_mux = nib_t'(cal.hr_t);
            A_DOW:   rd_mux = nib_t'(cal.dow);
            A_DAYU:  rd_mux = cal.day_u;
            A_DAYT:  rd_mux = nib_t'(cal.day_t);
            A_MONU:  rd_mux = cal.mon_u;
            A_MONT:  rd_mux = nib_t'(cal.mon_t);
            4'd1:    rd_mux = dig_val[0];
            4'd2:    rd_mux = dig_val[1];
            4'd3:    rd_mux = dig_val[2];
            default: rd_mux = '0;
        endcase
    end

    // Tick sampler, stop latch, changed flag and read register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q    <= 1'b0;
            hold_q    <= 1'b0;
            changed_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            tick_q <= tick_10hz;
            if (wr_en && bus_addr == A_HOLD) hold_q <= bus_wdata[0];
            if (step)       changed_q <= 1'b1;
            else if (rd_en) changed_q <= 1'b0;
            if (rd_en) rdata_q <= (changed_q || step) ? '1 : rd_mux;
            else       rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/rtc_nibble_regs_chk.sv
// Temporal checks for rtc_nibble_regs, bound to every instance of the top.
module rtc_nibble_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic [3:0] rdata,
    input logic       step,
    input logic       changed,
    input logic       hold,
    input logic [3:0] tenths,
    input logic [3:0] sec_u,
    input logic [3:0] sec_t
);
    AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == 4'h0);                                            // R1
    AST_TICK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> changed);                                                    // R6
    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !step) |=> !changed);                                       // R6
    AST_COLLISION_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (changed || step)) |=> rdata == 4'hF);                      // R7
    AST_HOLD_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (tenths == 4'd0 && sec_u == 4'd0 && sec_t == 4'd0));         // R8
    AST_TENTHS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !hold) |=> $stable(tenths));                                // R3
endmodule

bind rtc_nibble_regs rtc_nibble_regs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rdata   (bus_rdata),
    .step    (step),
    .changed (changed_q),
    .hold    (hold_q),
    .tenths  (dig_val[0]),
    .sec_u   (dig_val[1]),
    .sec_t   (dig_val[2])
);

// File: tb/tb_rtc_nibble_regs.sv
// Bench: behavioural reference model of the calendar compared with the read
// data port on every falling clock edge.
module tb_rtc_nibble_regs;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [3:0] addr = '0, wdata = '0;
    logic [3:0] rdata;

    int n_chk = 0, n_fail = 0;
    bit checking = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R11";

    // reference model state
    int m_ten, m_sec, m_min, m_hr, m_day, m_mon, m_dow, m_leap;
    int m_hold, m_flag, m_tq, m_rdata;

    rtc_nibble_regs dut (
        .clk(clk), .rst_n(rst_n), .tick_10hz(tick), .bus_sel(sel),
        .bus_rd(rd), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int dim(int mon, int leap);
        if (mon == 2) return (leap == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic int m_read(int a);
        case (a)
            1: return m_ten;
            2: return m_sec % 10;   3: return m_sec / 10;
            4: return m_min % 10;   5: return m_min / 10;
            6: return m_hr % 10;    7: return m_hr / 10;
            8: return m_dow;
            9: return m_day % 10;   10: return m_day / 10;
            11: return m_mon % 10;  12: return m_mon / 10;
            default: return 0;
        endcase
    endfunction

    task automatic m_advance();
        m_ten++;
        if (m_ten == 10) begin
            m_ten = 0; m_sec++;
            if (m_sec == 60) begin
                m_sec = 0; m_min++;
                if (m_min == 60) begin
                    m_min = 0; m_hr++;
                    if (m_hr == 24) begin
                        m_hr = 0;
                        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                        if (m_day == dim(m_mon, m_leap)) begin
                            m_day = 1;
                            if (m_mon == 12) begin m_mon = 1; m_leap = (m_leap + 1) % 4; end
                            else m_mon++;
                        end else m_day++;
                    end
                end
            end
        end
    endtask

    task automatic m_write(int a, int d);
        case (a)
            4:  m_min  = (m_min / 10) * 10 + d;
            5:  m_min  = (d & 7) * 10 + m_min % 10;
            6:  m_hr   = (m_hr / 10) * 10 + d;
            7:  m_hr   = (d & 3) * 10 + m_hr % 10;
            8:  m_dow  = d & 7;
            9:  m_day  = (m_day / 10) * 10 + d;
            10: m_day  = (d & 3) * 10 + m_day % 10;
            11: m_mon  = (m_mon / 10) * 10 + d;
            12: m_mon  = (d & 1) * 10 + m_mon % 10;
            13: m_leap = d & 3;
            14: m_hold = d & 1;
            default: ;
        endcase
    endtask

    // Reference model, one update per rising clock edge.
    always @(posedge clk) begin
        int stp, rv;
        if (!rst_n) begin
            m_ten = 0; m_sec = 0; m_min = 0; m_hr = 0;
            m_day = 1; m_mon = 1; m_dow = 1; m_leap = 0;
            m_hold = 0; m_flag = 0; m_tq = 0; m_rdata = 0;
        end else begin
            stp = (tick && m_tq == 0) ? 1 : 0;
            m_tq = tick ? 1 : 0;
            if (sel && rd) rv = (m_flag != 0 || stp != 0) ? 15 : m_read(int'(addr));
            else rv = 0;
            if (m_hold != 0) begin m_ten = 0; m_sec = 0; end
            else if (stp != 0) m_advance();
            if (sel && wr) m_write(int'(addr), int'(wdata));
            if (stp != 0) m_flag = 1;
            else if (sel && rd) m_flag = 0;
            m_rdata = rv;
        end
    end

    // Comparison on every falling edge.
    always @(negedge clk) begin
        if (checking && !finished) begin
            n_chk++;
            if (int'(rdata) != m_rdata || $isunknown(rdata)) begin
                n_fail++;
                $display("FAIL %s: read data actual %h expected %h at %0t",
                         cur_req, rdata, m_rdata[3:0], $time);
            end
        end
    end

    task automatic cyc(input logic r, input logic w, input int a, input int d, input logic t);
        @(negedge clk);
        sel = r | w; rd = r; wr = w; addr = 4'(a); wdata = 4'(d); tick = t;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0; wr = 1'b0; tick = 1'b0;
    endtask

    task automatic do_wr(int a, int d); cyc(1'b0, 1'b1, a, d, 1'b0); endtask
    task automatic do_rd(int a);        cyc(1'b1, 1'b0, a, 0, 1'b0); endtask
    task automatic do_tick(int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 0, 0, 1'b1);
    endtask

    // Zero the sub-minute digits, then run to the next minute carry.
    task automatic next_minute();
        do_wr(14, 1);
        do_wr(14, 0);
        do_tick(600);
    endtask

    task automatic set_date(int mon, int day, int dow);
        do_wr(11, mon % 10); do_wr(12, mon / 10);
        do_wr(9, day % 10);  do_wr(10, day / 10);
        do_wr(8, dow);
        do_wr(6, 3); do_wr(7, 2); do_wr(4, 9); do_wr(5, 5);
    endtask

    task automatic read_span(int lo, int hi);
        for (int a = lo; a <= hi; a++) do_rd(a);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL %s: watchdog actual timeout expected completion", cur_req);
            finish_run();
        end
    end

    initial begin
        @(posedge clk);
        checking = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R11";                  // reset contents over the whole map
        read_span(0, 15);

        cur_req = "R1";                   // writes to unused addresses, reads of 0/13/14/15
        do_wr(0, 9); do_wr(15, 7); do_wr(13, 0);
        do_rd(0); do_rd(13); do_rd(14); do_rd(15); do_rd(9);

        cur_req = "R3";                   // chain advance, long-high tick counts once
        do_tick(25);
        do_rd(1); do_rd(1); do_rd(2); do_rd(3);
        @(negedge clk); tick = 1'b1;
        repeat (4) @(negedge clk); tick = 1'b0;
        do_rd(1); do_rd(1);

        cur_req = "R6";                   // flag set by tick, cleared by read
        do_tick(1);
        do_rd(2); do_rd(2); do_rd(1);

        cur_req = "R7";                   // read in the tick-edge cycle
        cyc(1'b1, 1'b0, 1, 0, 1'b1);
        do_rd(1); do_rd(1);

        cur_req = "R9";                   // sub-minute writes ignored, loads, write beats advance
        do_wr(1, 7); do_wr(2, 5); do_wr(3, 4);
        read_span(1, 3);
        do_wr(4, 8); do_wr(5, 3); do_wr(6, 7); do_wr(7, 1);
        read_span(4, 7);
        cyc(1'b0, 1'b1, 4, 2, 1'b1);
        do_rd(4); do_rd(4); do_rd(1);

        cur_req = "R2";                   // masked fields
        do_wr(5, 15); do_wr(7, 15); do_wr(8, 15); do_wr(10, 15); do_wr(12, 15); do_wr(13, 15);
        do_rd(5); do_rd(7); do_rd(8); do_rd(10); do_rd(12); do_rd(13);
        do_wr(5, 0); do_wr(7, 0); do_wr(8, 1); do_wr(10, 0); do_wr(12, 0); do_wr(13, 0);
        read_span(4, 12);

        cur_req = "R8";                   // stop latch
        do_tick(13);
        do_wr(14, 1);
        do_tick(5);
        do_rd(1); do_rd(1); do_rd(2); do_rd(3); do_rd(14); do_rd(4);
        do_wr(14, 0);
        do_tick(2);
        do_rd(1); do_rd(1);

        cur_req = "R4";                   // 23:59 to 00:00, day advances
        set_date(1, 1, 1);
        next_minute();
        do_rd(1); read_span(1, 12);

        cur_req = "R5";                   // 30-day month end
        set_date(4, 30, 3);
        next_minute();
        do_rd(1); read_span(6, 12);

        cur_req = "R10";                  // February, non-leap position
        do_wr(13, 1);
        set_date(2, 28, 4);
        next_minute();
        do_rd(1); read_span(8, 12);

        cur_req = "R10";                  // February, leap position
        do_wr(13, 0);
        set_date(2, 28, 5);
        next_minute();
        do_rd(1); read_span(8, 12);
        next_minute();
        do_rd(1); read_span(8, 12);

        cur_req = "R5";                   // year end, day of week 7 to 1, leap advance
        do_wr(13, 3);
        set_date(12, 31, 7);
        next_minute();
        do_rd(1); read_span(4, 13);
        cur_req = "R10";                  // position 3 advanced to 0: Feb has 29 days
        set_date(2, 28, 2);
        next_minute();
        do_rd(1); read_span(8, 12);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule